// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This engine watches the load accesses a core performs. Each observed access carries the address of the load instruction and the data address it touched. A direct-mapped table, selected by low instruction-address bits, remembers for each load the data address it last used, the distance between its last two data addresses, and a small confidence score. When a load steps by the same non-zero distance twice in a row, the engine predicts that the load's next data address is the current one plus that distance. It then offers this address as a prefetch request. No software hint is involved: the table learns every pattern from the observed traffic alone.

Prefetch requests leave through a valid/ready port. The observation side has no ready signal and is never stalled, because a prefetch is only a hint. While a request waits for ready, `pf_valid` and `pf_addr` hold steady. A newer prediction replaces the waiting request in place, so the port keeps at most one pending request and that request is always the freshest one. A request is transferred on a rising clock edge where `pf_valid` and `pf_ready` are both high.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low and every table entry is empty, so the first observation of any instruction address produces no prefetch.
- R2: The entry is selected by `obs_pc[3:0]` and tagged by `obs_pc[31:4]`. A load whose tag differs from the resident one evicts it, and the evicted load's history is lost.
- R3: The stride is the current data address minus the stored one, and the prediction is the current address plus the stride, both computed modulo 2^32. Negative strides and wrap-around through zero are therefore handled.
- R4: An observation whose stride equals the stored non-zero stride raises `pf_valid` on the next clock edge, with `pf_addr` set to the prediction.
- R5: A newly allocated entry issues nothing on its first access, and nothing on its second access, where the stride is only learned.
- R6: A stride of zero never produces a prefetch, however often it repeats.
- R7: A stride that differs from the stored one issues nothing and replaces the stored stride. The next access that repeats the new stride issues a prefetch.
- R8: While `pf_ready` is low and nothing new is predicted, `pf_valid` and `pf_addr` stay unchanged. After an edge with `pf_valid` and `pf_ready` both high, and with no new prediction, `pf_valid` is low.
- R9: A new prediction made while a request is pending overwrites it, and the observation input is never stalled.
- R10: Loads in different table entries train and predict independently, even when their accesses are interleaved.
- R11: Replacing an entry clears its stride and confidence, so the new load needs two further accesses before it can issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_valid | input | 1 | An observed load access is present this cycle |
| obs_pc | input | 32 | Instruction address of the observed load |
| obs_addr | input | 32 | Data address of the observed load |
| pf_valid | output | 1 | Prefetch request pending |
| pf_addr | output | 32 | Predicted data address to prefetch |
| pf_ready | input | 1 | Consumer accepts the request on this edge |

## Verification
The hardest situation to reach from the ports is a pending request being overwritten while `pf_ready` is held low. It requires an entry that is already trained and a consumer that refuses delivery at the same time. The bench first trains one load with ready held low and checks that the request stays put over idle cycles. It then sends one more matching access and checks that the pending address changes to the newer prediction. Eviction is reached by aiming a second instruction address at an occupied index, and a later access by the evicted load then shows that its history is gone.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  localparam int CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  typedef enum logic [1:0] {
    LK_MISS  = 2'd0,
    LK_LEARN = 2'd1,
    LK_MATCH = 2'd2
  } lk_kind_e;

  function automatic logic [CONF_W-1:0] conf_up(input logic [CONF_W-1:0] c);
    return (c == CONF_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic [CONF_W-1:0] conf_down(input logic [CONF_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction
endpackage

// File: rtl/stride_pf_table.sv
module stride_pf_table
  import stride_pf_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 28,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_last,
  output logic [ADDR_W-1:0] rd_stride,
  output logic [CONF_W-1:0] rd_conf,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_last,
  input  logic [ADDR_W-1:0] wr_stride,
  input  logic [CONF_W-1:0] wr_conf
);
  localparam int DEPTH = 1 << IDX_W;

  logic              vld_q    [DEPTH];
  logic [TAG_W-1:0]  tag_q    [DEPTH];
  logic [ADDR_W-1:0] last_q   [DEPTH];
  logic [ADDR_W-1:0] stride_q [DEPTH];
  logic [CONF_W-1:0] conf_q   [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e]    <= 1'b0;
        tag_q[e]    <= '0;
        last_q[e]   <= '0;
        stride_q[e] <= '0;
        conf_q[e]   <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        vld_q[e]    <= 1'b1;
        tag_q[e]    <= wr_tag;
        last_q[e]   <= wr_last;
        stride_q[e] <= wr_stride;
        conf_q[e]   <= wr_conf;
      end
    end
  end

  assign rd_valid  = vld_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_last   = last_q[rd_idx];
  assign rd_stride = stride_q[rd_idx];
  assign rd_conf   = conf_q[rd_idx];
endmodule

// File: rtl/stride_pf_calc.sv
module stride_pf_calc
  import stride_pf_pkg::*;
#(
  parameter int TAG_W     = 28,
  parameter int ADDR_W    = 32,
  parameter int ISSUE_MIN = 1
) (
  input  logic [TAG_W-1:0]  obs_tag,
  input  logic [ADDR_W-1:0] obs_addr,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [ADDR_W-1:0] rd_last,
  input  logic [ADDR_W-1:0] rd_stride,
  input  logic [CONF_W-1:0] rd_conf,
  output lk_kind_e          kind,
  output logic [ADDR_W-1:0] nx_stride,
  output logic [CONF_W-1:0] nx_conf,
  output logic              issue,
  output logic [ADDR_W-1:0] pred_addr
);
  logic [ADDR_W-1:0] delta;
  logic              hit;

  assign hit       = rd_valid && (rd_tag == obs_tag);
  assign delta     = obs_addr - rd_last;
  assign pred_addr = obs_addr + delta;

  always_comb begin
    kind      = LK_MISS;
    nx_stride = '0;
    nx_conf   = '0;
    issue     = 1'b0;
    if (hit) begin
      if ((delta == rd_stride) && (delta != '0)) begin
        kind      = LK_MATCH;
        nx_stride = rd_stride;
        nx_conf   = conf_up(rd_conf);
        issue     = (int'(nx_conf) >= ISSUE_MIN);
      end else begin
        kind      = LK_LEARN;
        nx_stride = delta;
        nx_conf   = conf_down(rd_conf);
      end
    end
  end
endmodule

// File: rtl/stride_pf_outq.sv
module stride_pf_outq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (load) begin
      pf_valid <= 1'b1;
      pf_addr  <= load_addr;
    end else if (pf_valid && pf_ready) begin
      pf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
  import stride_pf_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int ISSUE_MIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  input  logic [PC_W-1:0]   obs_pc,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_ready
);
  localparam int TAG_W = PC_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_last, rd_stride, nx_stride, pred_addr;
  logic [CONF_W-1:0] rd_conf, nx_conf;
  lk_kind_e          kind;
  logic              issue;

  assign idx = obs_pc[IDX_W-1:0];
  assign tag = obs_pc[PC_W-1:IDX_W];

  stride_pf_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_last(rd_last), .rd_stride(rd_stride), .rd_conf(rd_conf),
    .wr_en(obs_valid), .wr_idx(idx), .wr_tag(tag),
    .wr_last(obs_addr), .wr_stride(nx_stride), .wr_conf(nx_conf)
  );

  stride_pf_calc #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .ISSUE_MIN(ISSUE_MIN)) u_calc (
    .obs_tag(tag), .obs_addr(obs_addr),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_last(rd_last),
    .rd_stride(rd_stride), .rd_conf(rd_conf),
    .kind(kind), .nx_stride(nx_stride), .nx_conf(nx_conf),
    .issue(issue), .pred_addr(pred_addr)
  );

  stride_pf_outq #(.ADDR_W(ADDR_W)) u_outq (
    .clk(clk), .rst_n(rst_n),
    .load(obs_valid && issue && (kind == LK_MATCH)), .load_addr(pred_addr),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );
endmodule

// File: rtl/stride_prefetcher_chk.sv
module stride_prefetcher_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              obs_valid,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              pf_ready
);
  // R8
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !obs_valid) |=> (pf_valid && $stable(pf_addr)));

  // R8
  drop_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && !obs_valid) |=> !pf_valid);

  // R8
  fall_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pf_valid) |-> $past(pf_ready));

  // R4
  rise_needs_obs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(obs_valid));

  // R9
  addr_change_needs_obs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && $past(pf_valid) && (pf_addr != $past(pf_addr))) |-> $past(obs_valid));

  // R1
  valid_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(pf_valid));
endmodule

bind stride_prefetcher stride_prefetcher_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid),
  .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
);

// File: tb/stride_prefetcher_bench.sv
module stride_prefetcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        obs_valid = 1'b0;
  logic [31:0] obs_pc = '0;
  logic [31:0] obs_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;
  logic        pf_ready = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  stride_prefetcher u_stride_prefetcher (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_pc(obs_pc),
    .obs_addr(obs_addr), .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] addr;
    logic        ev;
    logic [31:0] ea;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0100, 32'h0000_1000, 1'b0, 32'h0},           // R5 first access
    '{32'h0000_0100, 32'h0000_1040, 1'b0, 32'h0},           // R5 learn
    '{32'h0000_0100, 32'h0000_1080, 1'b1, 32'h0000_10C0},   // R4
    '{32'h0000_0100, 32'h0000_10C0, 1'b1, 32'h0000_1100},   // R4
    '{32'h0000_0204, 32'h0000_8000, 1'b0, 32'h0},           // R10
    '{32'h0000_0100, 32'h0000_1100, 1'b1, 32'h0000_1140},   // R10
    '{32'h0000_0204, 32'h0000_7FF8, 1'b0, 32'h0},           // R3
    '{32'h0000_0204, 32'h0000_7FF0, 1'b1, 32'h0000_7FE8},   // R3 negative
    '{32'h0000_0100, 32'h0000_1200, 1'b0, 32'h0},           // R7 mismatch
    '{32'h0000_0100, 32'h0000_1300, 1'b1, 32'h0000_1400},   // R7 relearned
    '{32'h0000_0110, 32'h0000_1400, 1'b0, 32'h0},           // R2 evict
    '{32'h0000_0110, 32'h0000_1500, 1'b0, 32'h0},           // R11 cleared stride
    '{32'h0000_0100, 32'h0000_1600, 1'b0, 32'h0},           // R2 history lost
    '{32'h0000_0300, 32'h0000_0050, 1'b0, 32'h0},           // R6
    '{32'h0000_0300, 32'h0000_0050, 1'b0, 32'h0},           // R6
    '{32'h0000_0300, 32'h0000_0050, 1'b0, 32'h0},           // R6
    '{32'h0000_0308, 32'hFFFF_FFF0, 1'b0, 32'h0},           // R3
    '{32'h0000_0308, 32'hFFFF_FFF8, 1'b0, 32'h0},           // R3
    '{32'h0000_0308, 32'h0000_0000, 1'b1, 32'h0000_0008}    // R3 wrap
  };

  task automatic check(input string req, input logic ev, input logic [31:0] ea);
    checks++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      fails++;
      $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
               req, pf_valid, pf_addr, ev, ea);
    end
  endtask

  task automatic observe(input logic [31:0] pc, input logic [31:0] addr);
    obs_valid = 1'b1;
    obs_pc    = pc;
    obs_addr  = addr;
    @(posedge clk); #1;
    obs_valid = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset", 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      observe(VECS[i].pc, VECS[i].addr);
      check($sformatf("vector %0d", i), VECS[i].ev, VECS[i].ea);
    end

    // R8 back-pressure hold
    pf_ready = 1'b0;
    observe(32'h0000_0400, 32'h0);
    observe(32'h0000_0400, 32'h4);
    observe(32'h0000_0400, 32'h8);
    check("R4 trained under back-pressure", 1'b1, 32'hC);
    for (int k = 0; k < 3; k++) begin
      idle();
      check("R8 hold while not ready", 1'b1, 32'hC);
    end
    // R9 overwrite of pending request
    observe(32'h0000_0400, 32'hC);
    check("R9 overwrite pending", 1'b1, 32'h10);
    pf_ready = 1'b1;
    idle();
    check("R8 drop after accept", 1'b0, 32'h0);

    // R1 reset clears table
    do_reset();
    check("R1 reset output", 1'b0, 32'h0);
    observe(32'h0000_0400, 32'h10);
    check("R1 table empty after reset", 1'b0, 32'h0);
    observe(32'h0000_0400, 32'h14);
    check("R5 learn after reset", 1'b0, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule